// File: doc/BRIEF.md
# Eight-Bit Arithmetic Unit with Condition Flags

This block is the execute stage of a small 8-bit processor datapath. Each cycle it takes two byte operands and a three-bit operation code. It returns the byte result combinationally. It can also latch a set of six condition flags into a status register on the rising clock edge. The supported operations are:

- add, and add with the stored carry
- subtract, and subtract with the stored carry acting as a borrow
- bitwise AND, OR and XOR
- a pass-through move of the second operand

The carry-in for the chained forms comes from the stored carry bit. A multi-byte sum or difference is therefore built one byte at a time, lowest byte first.

Flag writes are gated by an enable. The move operation never alters the flags, so a move can sit between the bytes of a chained computation without breaking the chain. Decode, fetch and memory access live outside the block.

Top module: `status_alu`

## Requirements
- R1: While reset (active-low, asynchronous) is asserted, and after its release until the first flag write, the status output is 0x00.
- R2: Operation codes are ADD=0, ADC=1, SUB=2, SBC=3, AND=4, OR=5, XOR=6, MOV=7. ADD returns (a+b) mod 256, and the latched carry is 1 exactly when the unsigned sum exceeds 255.
- R3: ADC returns (a+b+C) mod 256, where C is the stored carry bit, and sets carry when a+b+C exceeds 255.
- R4: SUB returns (a-b) mod 256, and SBC returns (a-b-C) mod 256. In both, the latched carry is a borrow: it is 1 exactly when b plus the borrow-in exceeds a as unsigned values.
- R5: Status bit positions are: bit 0 carry, bit 1 zero, bit 2 negative, bit 3 overflow, bit 4 sign, bit 5 half-carry, and bits 7:6 always 0. On a flag write, zero is 1 when the result is 0x00, and negative equals result bit 7.
- R6: On an arithmetic flag write, overflow is 1 exactly when the two's-complement result is out of range. Example: 0x40+0x40 gives 0x80 with overflow set.
- R7: The sign bit always equals negative XOR overflow.
- R8: Half-carry is the carry out of bit 3 for ADD/ADC. For SUB/SBC it is the borrow out of bit 3: the low nibble of b plus the borrow-in exceeds the low nibble of a.
- R9: AND, OR and XOR return the bitwise result, clear overflow, update zero, negative and sign, and keep carry and half-carry.
- R10: MOV returns operand b and leaves all status bits unchanged, even with the flag-write enable high.
- R11: With the flag-write enable low, the status register keeps its value for any operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; status updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Operation code (see R2) |
| opa | input | 8 | First operand (minuend for subtraction) |
| opb | input | 8 | Second operand (subtrahend; source for move) |
| flag_we | input | 1 | Flag-write enable |
| result | output | 8 | Combinational result byte |
| status | output | 8 | Registered condition flags |

## Verification
The bench first uses directed operand pairs:

- Sums that land exactly on 0x80 or wrap to 0x00 separate the overflow, carry, zero and half-carry rules from one another.
- Differences that borrow only in the low nibble, or only across the whole byte, separate the half-borrow from the full borrow.
- A two-byte add and a two-byte subtract show that the chained forms really read the stored carry.
- Moves and disabled writes placed just after a carry was set show that the flags are held.

A long run of random codes, operands and write enables is then compared, every cycle, against a reference model. The model works on signed and unsigned integers, so it exercises each flag rule independently of the carry chain.

// File: rtl/status_alu_pkg.sv
package status_alu_pkg;
   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_ADC = 3'd1,
      OP_SUB = 3'd2,
      OP_SBC = 3'd3,
      OP_AND = 3'd4,
      OP_OR  = 3'd5,
      OP_XOR = 3'd6,
      OP_MOV = 3'd7
   } alu_op_e;

   localparam int FLG_C = 0;
   localparam int FLG_Z = 1;
   localparam int FLG_N = 2;
   localparam int FLG_V = 3;
   localparam int FLG_S = 4;
   localparam int FLG_H = 5;
   localparam int FLG_COUNT = 6;
endpackage

// File: rtl/alu_arith.sv
// Ripple add/subtract core. Subtraction uses a + ~b + ~borrow, so the chain
// carries are inverted to give borrow semantics for the carry and half flags.
module alu_arith #(
   parameter int WIDTH    = 8,
   parameter int HALF_POS = 4
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cy_out,
   output logic             half_out,
   output logic             ovf_out
);
   localparam int CHAIN = WIDTH + 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("alu_arith: WIDTH must be at least 2");
   end
   if (HALF_POS < 1 || HALF_POS >= WIDTH) begin : g_bad_half
      $error("alu_arith: HALF_POS must lie inside the word");
   end

   logic [WIDTH-1:0] b_eff;
   logic [CHAIN-1:0] chain;

   assign b_eff    = sub ? ~b : b;
   assign chain[0] = sub ? ~cin : cin;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign sum[i]     = a[i] ^ b_eff[i] ^ chain[i];
      assign chain[i+1] = (a[i] & b_eff[i]) | (chain[i] & (a[i] ^ b_eff[i]));
   end

   assign cy_out   = chain[WIDTH] ^ sub;
   assign half_out = chain[HALF_POS] ^ sub;
   assign ovf_out  = chain[WIDTH] ^ chain[WIDTH-1];
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
   parameter int WIDTH = 8
) (
   input  logic [1:0]       fn,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] y
);
   always_comb begin
      unique case (fn)
         2'd0:    y = a & b;
         2'd1:    y = a | b;
         2'd2:    y = a ^ b;
         default: y = b;
      endcase
   end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg #(
   parameter int SW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [SW-1:0] d,
   output logic [SW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   assert_no_load_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> q == $past(q));
endmodule

// File: rtl/status_alu.sv
module status_alu
   import status_alu_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter int STATUS_W = 8,
   parameter int HALF_POS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          op_sel,
   input  logic [WIDTH-1:0]    opa,
   input  logic [WIDTH-1:0]    opb,
   input  logic                flag_we,
   output logic [WIDTH-1:0]    result,
   output logic [STATUS_W-1:0] status
);
   localparam int MSB = WIDTH - 1;

   if (STATUS_W < FLG_COUNT) begin : g_bad_status
      $error("status_alu: STATUS_W too small for the flag set");
   end

   alu_op_e op;
   logic    is_arith;
   logic    is_move;
   logic [WIDTH-1:0] arith_y, logic_y;
   logic    cy, half, ovf;
   logic [STATUS_W-1:0] status_d;

   assign op       = alu_op_e'(op_sel);
   assign is_arith = ~op_sel[2];
   assign is_move  = (op == OP_MOV);

   alu_arith #(.WIDTH(WIDTH), .HALF_POS(HALF_POS)) u_arith (
      .a(opa), .b(opb), .sub(op_sel[1]),
      .cin(op_sel[0] & status[FLG_C]),
      .sum(arith_y), .cy_out(cy), .half_out(half), .ovf_out(ovf)
   );

   alu_logic #(.WIDTH(WIDTH)) u_logic (
      .fn(op_sel[1:0]), .a(opa), .b(opb), .y(logic_y)
   );

   assign result = is_arith ? arith_y : logic_y;

   always_comb begin
      status_d        = '0;
      status_d[FLG_C] = is_arith ? cy   : status[FLG_C];
      status_d[FLG_H] = is_arith ? half : status[FLG_H];
      status_d[FLG_V] = is_arith & ovf;
      status_d[FLG_N] = result[MSB];
      status_d[FLG_Z] = (result == '0);
      status_d[FLG_S] = result[MSB] ^ (is_arith & ovf);
   end

   alu_status_reg #(.SW(STATUS_W)) u_status (
      .clk(clk), .rst_n(rst_n), .load(flag_we & ~is_move),
      .d(status_d), .q(status)
   );

   assert_move_keeps_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel == 3'd7) |=> status == $past(status));
   assert_sign_rule_R7: assert property (@(posedge clk) disable iff (!rst_n)
      status[FLG_S] == (status[FLG_N] ^ status[FLG_V]));
   assert_logic_clears_v_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel[2] && op_sel != 3'd7) |=>
         (!status[FLG_V] && status[FLG_C] == $past(status[FLG_C])
          && status[FLG_H] == $past(status[FLG_H])));
   assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel != 3'd7) |=> status[FLG_Z] == ($past(result) == '0));
   assert_add_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel == 3'd0) |=>
         status[FLG_V] == (($past(opa[MSB]) == $past(opb[MSB]))
                           && ($past(result[MSB]) != $past(opa[MSB]))));
   assert_upper_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      status[STATUS_W-1:FLG_COUNT] == '0);
endmodule

// File: tb/status_alu_bench.sv
`timescale 1ns/1ps
module status_alu_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] op_sel = '0;
   logic [7:0] opa = '0, opb = '0;
   logic       flag_we = 1'b0;
   logic [7:0] result, status;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference flags
   int mc = 0, mz = 0, mn = 0, mv = 0, ms = 0, mh = 0;
   string hold_tag = "";

   always #2 clk = ~clk;

   status_alu u_status_alu (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opa(opa), .opb(opb),
      .flag_we(flag_we), .result(result), .status(status)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_status();
      string t;
      t = (hold_tag != "") ? hold_tag : "R2/R4 carry";
      check(t, status[0], mc);
      check((hold_tag != "") ? hold_tag : "R5 zero", status[1], mz);
      check((hold_tag != "") ? hold_tag : "R5 negative", status[2], mn);
      check((hold_tag != "") ? hold_tag : "R6 overflow", status[3], mv);
      check((hold_tag != "") ? hold_tag : "R7 sign", status[4], ms);
      check((hold_tag != "") ? hold_tag : "R8 half", status[5], mh);
      check("R5 upper bits", int'(status[7:6]), 0);
   endtask

   task automatic step(input int op, input int a, input int b, input bit we);
      int r, cin, sa, sb, sr, nc, nh, nv;
      string rtag;
      @(negedge clk);
      op_sel = 3'(op); opa = 8'(a); opb = 8'(b); flag_we = we;
      #1;
      sa = (a > 127) ? a - 256 : a;
      sb = (b > 127) ? b - 256 : b;
      nc = mc; nh = mh; nv = 0;
      case (op)
         0, 1: begin
            cin = (op == 1) ? mc : 0;
            r = (a + b + cin) % 256;
            nc = (a + b + cin > 255) ? 1 : 0;
            nh = ((a % 16) + (b % 16) + cin > 15) ? 1 : 0;
            sr = sa + sb + cin;
            nv = (sr > 127 || sr < -128) ? 1 : 0;
            rtag = (op == 1) ? "R3" : "R2";
         end
         2, 3: begin
            cin = (op == 3) ? mc : 0;
            r = (a - b - cin + 512) % 256;
            nc = (b + cin > a) ? 1 : 0;
            nh = ((b % 16) + cin > (a % 16)) ? 1 : 0;
            sr = sa - sb - cin;
            nv = (sr > 127 || sr < -128) ? 1 : 0;
            rtag = "R4";
         end
         4: begin r = a & b; rtag = "R9"; end
         5: begin r = a | b; rtag = "R9"; end
         6: begin r = a ^ b; rtag = "R9"; end
         default: begin r = b; rtag = "R10"; end
      endcase
      check(rtag, result, r);
      check_status();
      @(posedge clk);
      if (we && op != 7) begin
         mc = nc; mh = nh; mv = nv;
         mn = (r >= 128) ? 1 : 0;
         mz = (r == 0) ? 1 : 0;
         ms = mn ^ mv;
      end
      hold_tag = !we ? "R11" : (op == 7) ? "R10" : "";
   endtask

   initial begin
      #20000000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #5;
      check("R1 reset", status, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", status, 8'h00);
      // directed cases
      step(0, 8'h40, 8'h40, 1);   // R6: 0x80, V=1, N=1, S=0
      step(0, 8'hFF, 8'h01, 1);   // R2: zero, carry, half
      step(1, 8'h00, 8'h00, 1);   // R3: adds stored carry -> 1
      step(0, 8'h0F, 8'h01, 1);   // R8 half only
      step(2, 8'h00, 8'h01, 1);   // R4 borrow -> 0xFF
      step(3, 8'h05, 8'h02, 1);   // R4 SBC uses borrow -> 2
      step(2, 8'h80, 8'h01, 1);   // R6 sub overflow
      step(2, 8'h10, 8'h01, 1);   // R8 half borrow only
      step(0, 8'hFF, 8'hFF, 1);   // sets C, H
      step(4, 8'hF0, 8'h0F, 1);   // R9 AND -> 0, C/H kept
      step(5, 8'h80, 8'h01, 1);   // R9 OR
      step(6, 8'hAA, 8'hAA, 1);   // R9 XOR -> 0
      step(0, 8'h40, 8'h40, 1);   // set V
      step(7, 8'h00, 8'h00, 1);   // R10 move zero, flags held
      step(0, 8'h00, 8'h00, 0);   // R11 write disabled
      step(6, 8'h01, 8'h00, 0);   // R11
      step(0, 8'h34, 8'hDC, 1);   // chained 16-bit add, low byte
      step(1, 8'h12, 8'h00, 1);   // R3 high byte takes carry
      step(2, 8'h00, 8'h01, 1);   // chained subtract low byte
      step(7, 8'h00, 8'h55, 1);   // R10 move between bytes
      step(3, 8'h01, 8'h00, 1);   // R4 high byte with borrow
      for (int i = 0; i < 3000; i++)
         step($urandom_range(0, 7), $urandom_range(0, 255),
              $urandom_range(0, 255), ($urandom_range(0, 3) != 0));
      @(negedge clk); #1;
      check_status();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule